// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between seven asynchronous processor control pins and the core's pending-interrupt and halt logic. Every pin first passes through a synchronizer chain. The block then compares it with a stored copy of the level it last accepted. A pin acts only when its synchronized level differs from that stored copy. The change is turned into the action for that pin: it drives a pending-interrupt request, latches a machine-check request, or halts or resumes the core. Some pins only have their new level recorded.

Pin indices are fixed. Bit 0 is the external interrupt, bit 1 the thermal interrupt, bit 2 the machine check, bit 3 the checkstop, bit 4 the hard reset, bit 5 the soft reset and bit 6 the time-base enable. The stored levels are visible as a 7-bit vector. The machine-check request stays latched until the core returns a one-cycle acknowledge.

Top module: `pin_conditioner`

## Requirements
- R1: A synchronous active-high reset clears every output to 0: all requests, the halt flag and the stored pin levels.
- R2: A level driven on `pin_in` reaches the outputs on the (SYNC_STAGES+1)th rising edge after it is applied, which is the third edge for the default of 2, and not earlier.
- R3: `pin_level_o[n]` holds the last accepted level of pin n: 0 external interrupt, 1 thermal, 2 machine check, 3 checkstop, 4 hard reset, 5 soft reset, 6 time-base enable.
- R4: `ext_irq_o` follows the accepted level of pin 0, which is active high.
- R5: `therm_irq_o` follows the accepted level of pin 1, which is active high.
- R6: A 1-to-0 change of accepted pin 2 sets `mck_req_o`. A 0-to-1 change of pin 2 does not set it.
- R7: `mck_req_o` stays set until a cycle with `mck_ack` high clears it. A new falling edge in the same cycle as the acknowledge wins, and the request stays set.
- R8: `halt_o` is 1 while the accepted level of pin 3 is high and 0 while it is low.
- R9: `sreset_irq_o` follows the accepted level of pin 5.
- R10: Changes on pins 4 and 6 alter only their bits of `pin_level_o` and no other output.
- R11: A pin held at its stored level produces no event. In particular, pin 2 held low after an acknowledge does not set `mck_req_o` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 7 | Asynchronous control pins, indexed as in R3 |
| mck_ack | input | 1 | Core acknowledge that clears the machine-check request |
| ext_irq_o | output | 1 | Pending external interrupt |
| therm_irq_o | output | 1 | Pending thermal interrupt |
| mck_req_o | output | 1 | Latched machine-check request |
| sreset_irq_o | output | 1 | Pending soft-reset interrupt |
| halt_o | output | 1 | Core halt flag |
| pin_level_o | output | 7 | Stored accepted pin levels |

## Verification
The bench builds the block with SYNC_STAGES = 2. Its reference model delays the pin history by that same parameter, so the three-edge latency of R2 is checked at exactly the cycle the pins are sampled. At this depth a short pin pulse can also be lost between samples or caught between them, and a falling machine-check edge can meet an acknowledge in the same cycle. Slowly toggling pseudo-random pins and random acknowledges bring the set-wins-over-clear case and held-low machine-check pins within reach.

// File: rtl/pinc_pkg.sv
package pinc_pkg;

    localparam int NPINS     = 7;
    localparam int PIN_EXT   = 0;
    localparam int PIN_THERM = 1;
    localparam int PIN_MCK   = 2;
    localparam int PIN_CKSTP = 3;
    localparam int PIN_HRST  = 4;
    localparam int PIN_SRST  = 5;
    localparam int PIN_TBEN  = 6;

    typedef struct packed {
        logic ext;
        logic therm;
        logic mck;
        logic srst;
        logic halt;
    } req_t;

    localparam req_t REQ_IDLE = '{default: 1'b0};

    // Next value for a level-following request: take the new level only on a change.
    function automatic logic follow(input logic cur, input logic chg, input logic lvl);
        return chg ? lvl : cur;
    endfunction

endpackage

// File: rtl/pinc_sync.sv
module pinc_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pinc_action.sv
module pinc_action
    import pinc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] smp,
    input  logic             ack,
    output req_t             req,
    output logic [NPINS-1:0] lvl
);
    logic [NPINS-1:0] lvl_q, lvl_d, chg, fall_ev;
    req_t             req_q, req_d;

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            assign chg[i]     = smp[i] ^ lvl_q[i];
            assign fall_ev[i] = chg[i] & lvl_q[i];
            assign lvl_d[i]   = chg[i] ? smp[i] : lvl_q[i];
        end
    endgenerate

    always_comb begin
        req_d       = req_q;
        req_d.ext   = follow(req_q.ext,   chg[PIN_EXT],   smp[PIN_EXT]);
        req_d.therm = follow(req_q.therm, chg[PIN_THERM], smp[PIN_THERM]);
        req_d.srst  = follow(req_q.srst,  chg[PIN_SRST],  smp[PIN_SRST]);
        req_d.halt  = follow(req_q.halt,  chg[PIN_CKSTP], smp[PIN_CKSTP]);
        if (ack)               req_d.mck = 1'b0;
        if (fall_ev[PIN_MCK])  req_d.mck = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            req_q <= REQ_IDLE;
        end else begin
            lvl_q <= lvl_d;
            req_q <= req_d;
        end
    end

    assign req = req_q;
    assign lvl = lvl_q;

    AST_MCK_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q.mck) |-> $fell(lvl_q[PIN_MCK])); // R6
    AST_MCK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(lvl_q[PIN_MCK]) |-> req_q.mck); // R6
    AST_MCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (req_q.mck && !ack) |=> req_q.mck); // R7
    AST_HALT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        req_q.halt == lvl_q[PIN_CKSTP]); // R8
    AST_EXT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$stable(req_q.ext) |-> !$stable(lvl_q[PIN_EXT])); // R11
    AST_LVL_FROM_PIN: assert property (@(posedge clk) disable iff (rst)
        !$stable(lvl_q) |-> lvl_q == $past(smp)); // R2
endmodule

// File: rtl/pin_conditioner.sv
module pin_conditioner
    import pinc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [6:0] pin_in,
    input  logic       mck_ack,
    output logic       ext_irq_o,
    output logic       therm_irq_o,
    output logic       mck_req_o,
    output logic       sreset_irq_o,
    output logic       halt_o,
    output logic [6:0] pin_level_o
);
    logic [NPINS-1:0] pin_sync;
    req_t             req;

    pinc_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    pinc_action u_act (
        .clk (clk),
        .rst (rst),
        .smp (pin_sync),
        .ack (mck_ack),
        .req (req),
        .lvl (pin_level_o)
    );

    assign ext_irq_o    = req.ext;
    assign therm_irq_o  = req.therm;
    assign mck_req_o    = req.mck;
    assign sreset_irq_o = req.srst;
    assign halt_o       = req.halt;
endmodule

// File: tb/pin_conditioner_test.sv
module pin_conditioner_test;
    localparam int STAGES = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] pin_in = '0;
    logic       mck_ack = 1'b0;
    logic       ext_irq_o, therm_irq_o, mck_req_o, sreset_irq_o, halt_o;
    logic [6:0] pin_level_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #2 clk = ~clk;

    pin_conditioner #(.SYNC_STAGES(STAGES)) uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .mck_ack(mck_ack),
        .ext_irq_o(ext_irq_o), .therm_irq_o(therm_irq_o), .mck_req_o(mck_req_o),
        .sreset_irq_o(sreset_irq_o), .halt_o(halt_o), .pin_level_o(pin_level_o)
    );

    // Behavioural reference: pin history queue delayed by STAGES edges.
    logic [6:0] hist[$];
    logic [6:0] m_lvl = '0;
    logic       m_mck = 0;

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            for (int i = 0; i < STAGES; i++) hist.push_back(7'h0);
            m_lvl = '0;
            m_mck = 0;
        end else begin
            logic [6:0] nw;
            hist.push_back(pin_in);
            nw = hist.pop_front();
            if (m_lvl[2] && !nw[2]) m_mck = 1;
            else if (mck_ack)       m_mck = 0;
            m_lvl = nw;
        end
    end

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            check("R3 pin_level", pin_level_o, m_lvl);
            check("R4 ext_irq", 7'(ext_irq_o), 7'(m_lvl[0]));
            check("R5 therm_irq", 7'(therm_irq_o), 7'(m_lvl[1]));
            check("R6 R7 mck_req", 7'(mck_req_o), 7'(m_mck));
            check("R8 halt", 7'(halt_o), 7'(m_lvl[3]));
            check("R9 sreset_irq", 7'(sreset_irq_o), 7'(m_lvl[5]));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        cyc(3);
        // R1: all outputs cleared under reset
        check("R1 reset outputs", {ext_irq_o, therm_irq_o, mck_req_o, sreset_irq_o, halt_o, 2'b00}, 7'h0);
        check("R1 reset levels", pin_level_o, 7'h0);
        rst = 0;
        cmp_on = 1;
        cyc(2);
        // R2: external pin reaches output on third edge only
        pin_in[0] = 1;
        cyc(2);
        check("R2 not before third edge", 7'(ext_irq_o), 7'h0);
        cyc(1);
        check("R2 third edge", 7'(ext_irq_o), 7'h1);
        // R6: rising machine check sets nothing; falling sets request
        pin_in[2] = 1;
        cyc(5);
        check("R6 rise no request", 7'(mck_req_o), 7'h0);
        pin_in[2] = 0;
        cyc(5);
        check("R6 fall sets request", 7'(mck_req_o), 7'h1);
        // R7 sticky then ack clears; R11 held low does not reassert
        cyc(4);
        check("R7 sticky", 7'(mck_req_o), 7'h1);
        mck_ack = 1; cyc(1); mck_ack = 0;
        check("R7 ack clears", 7'(mck_req_o), 7'h0);
        cyc(6);
        check("R11 held low quiet", 7'(mck_req_o), 7'h0);
        // R7 set wins over simultaneous ack
        pin_in[2] = 1; cyc(5);
        pin_in[2] = 0; cyc(2);
        mck_ack = 1; cyc(1); mck_ack = 0;
        check("R7 set beats ack", 7'(mck_req_o), 7'h1);
        mck_ack = 1; cyc(1); mck_ack = 0;
        // R8 checkstop halts and resumes
        pin_in[3] = 1; cyc(3);
        check("R8 halt set", 7'(halt_o), 7'h1);
        pin_in[3] = 0; cyc(3);
        check("R8 halt clear", 7'(halt_o), 7'h0);
        // R10 hard reset and time-base pins only change levels
        pin_in = 7'b1010001; cyc(3);
        check("R10 levels", pin_level_o, 7'b1010001);
        check("R10 other outputs", {ext_irq_o, therm_irq_o, mck_req_o, sreset_irq_o, halt_o, 2'b00}, 7'b1000000);
        // R9 soft reset follows
        pin_in[5] = 1; cyc(3);
        check("R9 sreset", 7'(sreset_irq_o), 7'h1);
        // Pseudo-random slow toggling with random acknowledges
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] < 4) pin_in[lfsr[6:4] % 7] = ~pin_in[lfsr[6:4] % 7];
            mck_ack = (lfsr[11:9] == 3'b101);
            cyc(1);
        end
        mck_ack = 0;
        cyc(4);
        finish_run();
    end
endmodule